// File: doc/BRIEF.md
# Window Overlay Priority and Pixel Color Composer

This block turns the per-pixel information of a text overlay into the signals sent to the video amplifiers: a 3-bit RGB value, a fast-blank strobe that switches the amplifiers over to the overlay, and a half-tone strobe that dims the picture under translucent backgrounds. Each clock it receives the character cell being drawn (row and column), the glyph luminance dot, the two glyph edge dots, the character's two color-select bits and the row's eight-entry palette. It also receives the registers of four rectangular background windows and a few global controls.

The four windows are tested against the cell position, and the enabled one with the lowest index wins any overlap. Character luminance then has priority over the black edge, the edge over the winning window color, and the window over transparency. A window may carry an extended-color flag, which moves the characters drawn over it to the upper half of the palette. The block is a single registered stage. Glyph lookup and raster timing are handled outside it.

Top module: `osdPixelComposer`

## Requirements
- R1: Window i (i = 0..3) covers a cell when its enable bit `winEnable[i]` is 1 and rowStart <= row <= rowEnd and colStart <= col <= colEnd, all bounds inclusive. Its row fields sit at bits [4i+3:4i], its column fields at [5i+4:5i] and its color at `winColor[3i+2:3i]`. RGB bit 2 is red, bit 1 green and bit 0 blue.
- R2: A window whose row start is greater than its row end, or whose column start is greater than its column end, covers no cell, whatever its enable bit says.
- R3: Where several windows cover a cell, the one with the lowest index supplies the window color and the extended-color flag.
- R4: A lit character pixel takes palette entry `colorSel` (00 to 11 select entries 0 to 3). Entry n sits at `rowPalette[3n+2:3n]`.
- R5: If the winning window has `winExt` set, a lit character pixel over it takes palette entry 4 + `colorSel` instead.
- R6: With `edgeEn` = 1, the edge dot is `edgeAll` when `shadowSel` = 0 (outline on four sides) and `edgeRB` when `shadowSel` = 1 (right and bottom only). An edge pixel is black (000). With `edgeEn` = 0 both edge inputs have no effect.
- R7: Output color priority, highest first: lit character, edge (black), winning window color, transparent (000).
- R8: With `fbCharOnly` = 0, `fastBlank` is 1 over character or edge pixels and over any covered cell. With `fbCharOnly` = 1, it is 1 only over character or edge pixels.
- R9: `forceBlank` = 1 drives `fastBlank` to 1 regardless of every other input.
- R10: With `doubleWidth` = 1, the luminance and edge dots of odd columns are discarded. Such a pixel shows only the window color or transparency.
- R11: `halfTone` is 1 exactly when a window covers the cell and no lit character pixel is drawn.
- R12: All outputs are registered and reflect the inputs of the previous clock edge. During reset they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowIdx | input | 4 | Character row of the current pixel |
| colIdx | input | 5 | Character column of the current pixel |
| lumaDot | input | 1 | Glyph luminance dot |
| edgeAll | input | 1 | Edge dot of the four-sided outline |
| edgeRB | input | 1 | Edge dot of the right/bottom shadow |
| edgeEn | input | 1 | Enables edge drawing |
| shadowSel | input | 1 | 1 selects shadow, 0 selects outline |
| colorSel | input | 2 | Per-character palette select |
| doubleWidth | input | 1 | Current row is drawn at double width |
| rowPalette | input | 24 | Eight 3-bit RGB palette entries |
| winRowStart | input | 16 | Four 4-bit window row starts |
| winRowEnd | input | 16 | Four 4-bit window row ends |
| winColStart | input | 20 | Four 5-bit window column starts |
| winColEnd | input | 20 | Four 5-bit window column ends |
| winEnable | input | 4 | Window enable bits |
| winExt | input | 4 | Window extended-color flags |
| winColor | input | 12 | Four 3-bit window colors |
| fbCharOnly | input | 1 | Fast blank over characters only |
| forceBlank | input | 1 | Forces fast blank high |
| pixRgb | output | 3 | Composed pixel color |
| fastBlank | output | 1 | Fast-blank strobe |
| halfTone | output | 1 | Half-tone strobe |

## Verification
The block keeps no state beyond its output register, so any fault shows up at the ports one clock after the pixel that triggers it and never persists beyond that pixel. A wrong priority choice appears as the color of a lower-priority window, or as the wrong palette half, on the exact cells where windows overlap. A wrong bound comparison appears only on the first or last row or column of a window. For that reason the windows are driven with small, overlapping and inverted bounds, together with random cell positions.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int NUM_WIN   = 4;
  localparam int ROW_W     = 4;
  localparam int COL_W     = 5;
  localparam int RGB_W     = 3;
  localparam int SEL_W     = 2;
  localparam int PAL_IDX_W = SEL_W + 1;
  localparam int PAL_N     = 1 << PAL_IDX_W;

  typedef struct packed {
    logic [NUM_WIN-1:0] winOneHot;
    logic               anyWin;
    logic               extSel;
    logic               charOn;
    logic               edgeOn;
  } pixStrobe_t;
endpackage

// File: rtl/osdWinCtrl.sv
module osdWinCtrl
  import osd_pkg::*;
(
  input  logic [ROW_W-1:0]         rowIdx,
  input  logic [COL_W-1:0]         colIdx,
  input  logic                     lumaDot,
  input  logic                     edgeAll,
  input  logic                     edgeRB,
  input  logic                     edgeEn,
  input  logic                     shadowSel,
  input  logic                     doubleWidth,
  input  logic [NUM_WIN*ROW_W-1:0] winRowStart,
  input  logic [NUM_WIN*ROW_W-1:0] winRowEnd,
  input  logic [NUM_WIN*COL_W-1:0] winColStart,
  input  logic [NUM_WIN*COL_W-1:0] winColEnd,
  input  logic [NUM_WIN-1:0]       winEnable,
  input  logic [NUM_WIN-1:0]       winExt,
  output pixStrobe_t               strobe
);
  logic [NUM_WIN-1:0] winHit;
  logic [NUM_WIN-1:0] oneHot;
  logic               hidden;
  logic               edgeDot;

  // per-window rectangle test; inverted bounds never match
  for (genvar gw = 0; gw < NUM_WIN; gw++) begin : gWin
    logic [ROW_W-1:0] rS, rE;
    logic [COL_W-1:0] cS, cE;
    assign rS = winRowStart[gw*ROW_W +: ROW_W];
    assign rE = winRowEnd[gw*ROW_W +: ROW_W];
    assign cS = winColStart[gw*COL_W +: COL_W];
    assign cE = winColEnd[gw*COL_W +: COL_W];
    assign winHit[gw] = winEnable[gw] && (rS <= rE) && (cS <= cE) &&
                        (rowIdx >= rS) && (rowIdx <= rE) &&
                        (colIdx >= cS) && (colIdx <= cE);
  end

  // lowest index wins
  always_comb begin
    oneHot = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winHit[i]) begin
        oneHot    = '0;
        oneHot[i] = 1'b1;
      end
    end
  end

  assign hidden  = doubleWidth && colIdx[0];
  assign edgeDot = shadowSel ? edgeRB : edgeAll;

  always_comb begin
    strobe.winOneHot = oneHot;
    strobe.anyWin    = |winHit;
    strobe.extSel    = |(oneHot & winExt);
    strobe.charOn    = lumaDot && !hidden;
    strobe.edgeOn    = edgeEn && edgeDot && !hidden;
  end
endmodule

// File: rtl/osdColorPath.sv
module osdColorPath
  import osd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  pixStrobe_t               strobe,
  input  logic [SEL_W-1:0]         colorSel,
  input  logic [PAL_N*RGB_W-1:0]   rowPalette,
  input  logic [NUM_WIN*RGB_W-1:0] winColor,
  input  logic                     fbCharOnly,
  input  logic                     forceBlank,
  output logic [RGB_W-1:0]         pixRgb,
  output logic                     fastBlank,
  output logic                     halfTone
);
  logic [PAL_IDX_W-1:0] palIdx;
  logic [RGB_W-1:0]     charRgb;
  logic [RGB_W-1:0]     winRgb;
  logic [RGB_W-1:0]     nextRgb;
  logic                 glyphOn;

  assign palIdx  = {strobe.extSel, colorSel};
  assign charRgb = rowPalette[palIdx*RGB_W +: RGB_W];
  assign glyphOn = strobe.charOn || strobe.edgeOn;

  always_comb begin
    winRgb = '0;
    for (int i = 0; i < NUM_WIN; i++)
      winRgb |= {RGB_W{strobe.winOneHot[i]}} & winColor[i*RGB_W +: RGB_W];
  end

  always_comb begin
    if (strobe.charOn)      nextRgb = charRgb;
    else if (strobe.edgeOn) nextRgb = '0;
    else if (strobe.anyWin) nextRgb = winRgb;
    else                    nextRgb = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixRgb    <= '0;
      fastBlank <= 1'b0;
      halfTone  <= 1'b0;
    end else begin
      pixRgb    <= nextRgb;
      fastBlank <= forceBlank || glyphOn || (strobe.anyWin && !fbCharOnly);
      halfTone  <= strobe.anyWin && !strobe.charOn;
    end
  end

  assert_force_blank_R9: assert property (@(posedge clk) disable iff (!rstN)
    forceBlank |=> fastBlank);
  assert_edge_black_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.edgeOn && !strobe.charOn) |=> (pixRgb == '0));
  assert_half_tone_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.charOn |=> !halfTone);
  assert_char_only_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fbCharOnly && !forceBlank && !glyphOn) |=> !fastBlank);
endmodule

// File: rtl/osdPixelComposer.sv
module osdPixelComposer
  import osd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ROW_W-1:0]         rowIdx,
  input  logic [COL_W-1:0]         colIdx,
  input  logic                     lumaDot,
  input  logic                     edgeAll,
  input  logic                     edgeRB,
  input  logic                     edgeEn,
  input  logic                     shadowSel,
  input  logic [SEL_W-1:0]         colorSel,
  input  logic                     doubleWidth,
  input  logic [PAL_N*RGB_W-1:0]   rowPalette,
  input  logic [NUM_WIN*ROW_W-1:0] winRowStart,
  input  logic [NUM_WIN*ROW_W-1:0] winRowEnd,
  input  logic [NUM_WIN*COL_W-1:0] winColStart,
  input  logic [NUM_WIN*COL_W-1:0] winColEnd,
  input  logic [NUM_WIN-1:0]       winEnable,
  input  logic [NUM_WIN-1:0]       winExt,
  input  logic [NUM_WIN*RGB_W-1:0] winColor,
  input  logic                     fbCharOnly,
  input  logic                     forceBlank,
  output logic [RGB_W-1:0]         pixRgb,
  output logic                     fastBlank,
  output logic                     halfTone
);
  pixStrobe_t strobe;

  osdWinCtrl i_ctrl (
    .rowIdx(rowIdx), .colIdx(colIdx), .lumaDot(lumaDot),
    .edgeAll(edgeAll), .edgeRB(edgeRB), .edgeEn(edgeEn),
    .shadowSel(shadowSel), .doubleWidth(doubleWidth),
    .winRowStart(winRowStart), .winRowEnd(winRowEnd),
    .winColStart(winColStart), .winColEnd(winColEnd),
    .winEnable(winEnable), .winExt(winExt), .strobe(strobe)
  );

  osdColorPath i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .colorSel(colorSel),
    .rowPalette(rowPalette), .winColor(winColor),
    .fbCharOnly(fbCharOnly), .forceBlank(forceBlank),
    .pixRgb(pixRgb), .fastBlank(fastBlank), .halfTone(halfTone)
  );

  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.winOneHot) && (strobe.anyWin == (strobe.winOneHot != '0)));
  assert_odd_hidden_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doubleWidth && colIdx[0] && fbCharOnly && !forceBlank) |=> !fastBlank);
endmodule

// File: tb/test_osdPixelComposer.sv
module test_osdPixelComposer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rowIdx = '0;
  logic [4:0]  colIdx = '0;
  logic        lumaDot = 0, edgeAll = 0, edgeRB = 0, edgeEn = 0, shadowSel = 0;
  logic [1:0]  colorSel = '0;
  logic        doubleWidth = 0;
  logic [23:0] rowPalette = '0;
  logic [15:0] winRowStart = '0, winRowEnd = '0;
  logic [19:0] winColStart = '0, winColEnd = '0;
  logic [3:0]  winEnable = '0, winExt = '0;
  logic [11:0] winColor = '0;
  logic        fbCharOnly = 0, forceBlank = 0;
  logic [2:0]  pixRgb;
  logic        fastBlank, halfTone;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  osdPixelComposer i_osdPixelComposer (.*);

  // reference model built from the requirement text
  function automatic logic [4:0] refModel();
    int win = -1;
    logic chr, edg, ext;
    logic [2:0] rgb;
    logic fb, ht;
    for (int i = 3; i >= 0; i--) begin
      logic [3:0] rs, re;
      logic [4:0] cs, ce;
      rs = winRowStart[i*4 +: 4]; re = winRowEnd[i*4 +: 4];
      cs = winColStart[i*5 +: 5]; ce = winColEnd[i*5 +: 5];
      if (winEnable[i] && rs <= re && cs <= ce && rowIdx >= rs && rowIdx <= re &&
          colIdx >= cs && colIdx <= ce) win = i;
    end
    chr = lumaDot && !(doubleWidth && colIdx[0]);
    edg = edgeEn && (shadowSel ? edgeRB : edgeAll) && !(doubleWidth && colIdx[0]);
    ext = (win >= 0) && winExt[win];
    if (chr) rgb = rowPalette[(ext ? 4 + colorSel : colorSel)*3 +: 3];
    else if (edg) rgb = 3'b000;
    else if (win >= 0) rgb = winColor[win*3 +: 3];
    else rgb = 3'b000;
    fb = forceBlank || chr || edg || ((win >= 0) && !fbCharOnly);
    ht = (win >= 0) && !chr;
    return {rgb, fb, ht};
  endfunction

  task automatic compare(string tag, logic [4:0] exp);
    checks++;
    if ({pixRgb, fastBlank, halfTone} !== exp) begin
      fails++;
      $display("FAIL %s: rgb/fb/ht actual %b/%b/%b expected %b/%b/%b", tag,
               pixRgb, fastBlank, halfTone, exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic step(string tag);
    logic [4:0] exp;
    exp = refModel();
    @(posedge clk);
    #2;
    compare(tag, exp);
  endtask

  task automatic setCell(int r, int c, bit l, bit ea, bit er);
    rowIdx = 4'(r); colIdx = 5'(c); lumaDot = l; edgeAll = ea; edgeRB = er;
  endtask

  task automatic setWin(int i, int rs, int re, int cs, int ce, bit en, bit ex, int col);
    winRowStart[i*4 +: 4] = 4'(rs); winRowEnd[i*4 +: 4] = 4'(re);
    winColStart[i*5 +: 5] = 5'(cs); winColEnd[i*5 +: 5] = 5'(ce);
    winEnable[i] = en; winExt[i] = ex; winColor[i*3 +: 3] = 3'(col);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int n = 0; n < 8; n++) rowPalette[n*3 +: 3] = 3'((n + 1) % 8);
    setCell(2, 3, 1, 1, 1);
    forceBlank = 1;
    repeat (3) @(posedge clk);
    #2;
    compare("R12 reset", 5'b0);
    rstN = 1'b1;
    forceBlank = 0;
    #8;

    setWin(0, 2, 4, 3, 8, 1, 0, 3'b001);
    setWin(1, 3, 6, 5, 12, 1, 1, 3'b010);
    setWin(2, 5, 1, 0, 31, 1, 0, 3'b100);
    setWin(3, 0, 9, 20, 31, 1, 0, 3'b110);

    setCell(2, 3, 0, 0, 0); step("R1 corner cell");
    setCell(4, 8, 0, 0, 0); step("R1 far corner");
    setCell(1, 3, 0, 0, 0); step("R1 outside row");
    setCell(3, 6, 0, 0, 0); step("R3 overlap w0 over w1");
    setCell(6, 11, 0, 0, 0); step("R3 w1 alone");
    setCell(7, 10, 0, 0, 0); step("R2 row-inverted window");
    setWin(2, 0, 9, 10, 9, 1, 0, 3'b100);
    setCell(7, 9, 0, 0, 0); step("R2 column-inverted window");
    setCell(0, 0, 1, 0, 0);
    for (int s = 0; s < 4; s++) begin colorSel = 2'(s); step("R4 palette select"); end
    setCell(6, 11, 1, 0, 0); colorSel = 2'd2; step("R5 extended palette");
    setCell(3, 6, 1, 0, 0); step("R5 winner without ext");
    edgeEn = 1;
    setCell(6, 11, 0, 1, 0); shadowSel = 0; step("R6 outline edge");
    setCell(6, 11, 0, 0, 1); step("R6 shadow dot ignored in outline");
    shadowSel = 1; step("R6 shadow edge");
    edgeEn = 0; setCell(6, 11, 0, 1, 1); step("R6 edges off");
    edgeEn = 1; setCell(6, 11, 1, 1, 1); step("R7 luma over edge");
    fbCharOnly = 1; setCell(6, 11, 0, 0, 0); step("R8 char-only blank");
    setCell(6, 11, 1, 0, 0); step("R8 char-only over char");
    fbCharOnly = 0; forceBlank = 1; setCell(15, 31, 0, 0, 0);
    winEnable = '0; step("R9 force blank");
    forceBlank = 0; winEnable = 4'hF;
    doubleWidth = 1; fbCharOnly = 1;
    setCell(0, 1, 1, 1, 1); step("R10 odd column hidden");
    setCell(6, 11, 1, 1, 1); step("R10 odd column over window");
    setCell(0, 2, 1, 1, 1); step("R10 even column shown");
    doubleWidth = 0; fbCharOnly = 0;
    setCell(6, 11, 0, 1, 0); shadowSel = 0; step("R11 half tone under edge");

    for (int k = 0; k < 600; k++) begin
      if (k % 25 == 0) begin
        for (int w = 0; w < 4; w++)
          setWin(w, $urandom_range(0, 9), $urandom_range(0, 9),
                 $urandom_range(0, 31), $urandom_range(0, 31),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7));
        rowPalette = 24'($urandom);
      end
      setCell($urandom_range(0, 9), $urandom_range(0, 31), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 1));
      colorSel = 2'($urandom); edgeEn = $urandom_range(0, 1);
      shadowSel = $urandom_range(0, 1); doubleWidth = $urandom_range(0, 3) == 0;
      fbCharOnly = $urandom_range(0, 1); forceBlank = $urandom_range(0, 7) == 0;
      step("R7 random mix");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule